// File: doc/BRIEF.md
# Indexed-Colour Display Control Registers

This block holds the programmable state of an 8-bit indexed-colour display engine behind a 32-bit, word-access register bus. Software programs a 256-entry colour lookup table, a three-colour cursor lookup table, a 512-word cursor bitmap, and a handful of scalar settings. The scalar settings are the visible width and height, the start offset of the screen in video memory, a control word and the cursor position. The block decodes every access, stores the values, formats readback and reports accesses that hit no register. The raster engine reads the decoded geometry, depth, blanking and cursor controls directly from output ports. It looks up colours through a dedicated index port.

Several settings are kept in scaled or packed form. Width is programmed in groups of four pixels and height in half-lines. A 3-bit code selects the pixel depth through a fixed non-linear table. The addresses of the video-timing registers are accepted and have no effect. The raster engine pulses a frame-complete input, and the block turns that into a level interrupt. Software clears the interrupt with any register write. A dedicated address returns all register state to zero.

Top module: `fb_ctrl_regs`

## Requirements
- R1: A write to 0x800 + 8*n (n = 0..255) stores red from wdata[23:16], green from [15:8] and blue from [7:0] into colour entry n. Driving `pal_idx` = n makes `pal_rgb` = {R,G,B} one clock later. These addresses are write-only.
- R2: Cursor colours 0..2 sit at 0x508, 0x510 and 0x518, with the same packing as R1. A read returns {8'h00, R, G, B}.
- R3: Cursor bitmap word n (n = 0..511) sits at 0x1000 + 8*n. A write keeps wdata[15:0], and a read returns it zero-extended to 32 bits.
- R4: A write of v to 0x118 makes `disp_width` = v*4, truncated to 32 bits. A read of 0x118 returns `disp_width`/4.
- R5: A write of v to 0x150 makes `disp_height` = v/2. A read of 0x150 returns `disp_height`*2.
- R6: 0x300 holds the control word, which reads back unchanged. `disp_blank` follows bit 10 and `cursor_en` is the inverse of bit 23. Bits 22:20 set `disp_bpp` as follows: codes 0, 1, 2, 3, 4 and 5 give 1, 2, 4, 8, 15 and 16, and codes 6 and 7 give 0.
- R7: A write to 0x400 sets `screen_base`. A write to 0x638 sets the cursor position, with `cursor_x` = wdata[31:12] and `cursor_y` = wdata[11:0]. Both addresses are write-only.
- R8: A write to 0x100000 clears every colour entry, cursor colour, bitmap word, width, height, control word, offset and cursor position to zero. It also clears `irq` unless `frame_done` is high in the same cycle.
- R9: Writes to 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change no state and raise no error.
- R10: `frame_done` sets `irq` on the next edge. Any bus write clears `irq`. When a write and `frame_done` fall in the same cycle, `irq` ends up set.
- R11: A read of an address that is not readable (including the write-only registers of R1, R7, R8 and R9) returns zero and pulses `bus_err` for one cycle. A write to an address outside R1–R9 changes nothing and pulses `bus_err`.
- R12: `bus_rdata` and `bus_err` are registered and valid in the cycle after the access. When no read or bad access occurs they are zero. A read that coincides with a write returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 21 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after `bus_re` |
| bus_err | output | 1 | One-cycle pulse for an unmapped access |
| frame_done | input | 1 | Frame-complete pulse from the raster engine |
| irq | output | 1 | Frame interrupt level |
| pal_idx | input | 8 | Colour lookup index |
| pal_rgb | output | 24 | Colour for `pal_idx`, one cycle later |
| disp_width | output | 32 | Visible width in pixels |
| disp_height | output | 32 | Visible height in lines |
| screen_base | output | 32 | Start offset of the screen in video memory |
| ctrl_word | output | 32 | Raw control word |
| disp_bpp | output | 5 | Bits per pixel, 0 when unsupported |
| disp_blank | output | 1 | Force blank |
| cursor_en | output | 1 | Cursor enabled |
| cursor_x | output | 20 | Cursor X coordinate |
| cursor_y | output | 12 | Cursor Y coordinate |

## Verification
The interrupt has two causes that can fall in the same cycle: a `frame_done` pulse sets it, and any bus write clears it. The bench drives both in one cycle and requires `irq` to be high afterwards. A lone write that follows must then clear it. A second collision is a read and a write to the same width register in one cycle. The read data must show the value from before the write, and the output must show the new width.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    localparam int FBC_AW = 21;
    localparam int FBC_DW = 32;

    localparam logic [FBC_AW-1:0] A_CLUT   = 21'h000800;
    localparam logic [FBC_AW-1:0] A_CLUT_E = 21'h001000;
    localparam logic [FBC_AW-1:0] A_CPAT   = 21'h001000;
    localparam logic [FBC_AW-1:0] A_CPAT_E = 21'h002000;
    localparam logic [FBC_AW-1:0] A_CPAL   = 21'h000508;
    localparam logic [FBC_AW-1:0] A_CPAL_E = 21'h000520;
    localparam logic [FBC_AW-1:0] A_WIDTH  = 21'h000118;
    localparam logic [FBC_AW-1:0] A_HEIGHT = 21'h000150;
    localparam logic [FBC_AW-1:0] A_CTRL   = 21'h000300;
    localparam logic [FBC_AW-1:0] A_BASE   = 21'h000400;
    localparam logic [FBC_AW-1:0] A_CPOS   = 21'h000638;
    localparam logic [FBC_AW-1:0] A_SRST   = 21'h100000;

    typedef enum logic [3:0] {
        RG_NONE, RG_CLUT, RG_CPAT, RG_CPAL, RG_WIDTH, RG_HEIGHT,
        RG_CTRL, RG_BASE, RG_CPOS, RG_SRST, RG_TIMING
    } fbc_region_e;

    typedef struct packed {
        logic       blank;
        logic       cursor_off;
        logic [2:0] depth_code;
    } fbc_ctrl_view_t;

    function automatic fbc_ctrl_view_t fbc_view(input logic [31:0] cw);
        fbc_ctrl_view_t v;
        v.blank      = cw[10];
        v.cursor_off = cw[23];
        v.depth_code = cw[22:20];
        return v;
    endfunction

    function automatic logic [4:0] fbc_depth_bpp(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd1;
            3'd1:    return 5'd2;
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            3'd4:    return 5'd15;
            3'd5:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/fbc_decode.sv
module fbc_decode
    import fbc_pkg::*;
(
    input  logic [FBC_AW-1:0] addr,
    output fbc_region_e       region,
    output logic [8:0]        idx,
    output logic              rd_ok
);
    always_comb begin
        region = RG_NONE;
        idx    = '0;
        if (addr >= A_CLUT && addr < A_CLUT_E) begin
            region = RG_CLUT;
            idx    = {1'b0, addr[10:3]};
        end else if (addr >= A_CPAT && addr < A_CPAT_E) begin
            region = RG_CPAT;
            idx    = addr[11:3];
        end else if (addr >= A_CPAL && addr < A_CPAL_E) begin
            region = RG_CPAL;
            idx    = 9'((addr - A_CPAL) >> 3);
        end else begin
            case (addr)
                A_WIDTH:  region = RG_WIDTH;
                A_HEIGHT: region = RG_HEIGHT;
                A_CTRL:   region = RG_CTRL;
                A_BASE:   region = RG_BASE;
                A_CPOS:   region = RG_CPOS;
                A_SRST:   region = RG_SRST;
                21'h000000, 21'h000108, 21'h000110, 21'h000120,
                21'h000128, 21'h000130, 21'h000138, 21'h000140,
                21'h000148, 21'h000158, 21'h000160, 21'h000168,
                21'h000170, 21'h000200:
                          region = RG_TIMING;
                default:  region = RG_NONE;
            endcase
        end
    end

    assign rd_ok = (region == RG_CPAT) || (region == RG_CPAL) ||
                   (region == RG_WIDTH) || (region == RG_HEIGHT) ||
                   (region == RG_CTRL);
endmodule

// File: rtl/fbc_table.sv
module fbc_table #(
    parameter int DEPTH = 256,
    parameter int DW    = 24,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdat,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdat
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && (int'(widx) < DEPTH)) begin
            mem[widx] <= wdat;
        end
    end

    generate
        if (DEPTH == (1 << IW)) begin : g_full
            assign rdat = mem[ridx];
        end else begin : g_part
            assign rdat = (int'(ridx) < DEPTH) ? mem[ridx] : '0;
        end
    endgenerate
endmodule

// File: rtl/fbc_irq.sv
module fbc_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)      irq <= 1'b0;
        else if (set) irq <= 1'b1;
        else if (clr) irq <= 1'b0;
    end

    // R10: a frame event always leaves the line raised
    a_r10_frame_sets: assert property (@(posedge clk) disable iff (rst)
        set |=> irq);
    // R10: a write without a frame event lowers the line
    a_r10_write_clears: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !irq);
endmodule

// File: rtl/fb_ctrl_regs.sv
module fb_ctrl_regs
    import fbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [20:0] bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_we,
    input  logic        bus_re,
    output logic [31:0] bus_rdata,
    output logic        bus_err,
    input  logic        frame_done,
    output logic        irq,
    input  logic [7:0]  pal_idx,
    output logic [23:0] pal_rgb,
    output logic [31:0] disp_width,
    output logic [31:0] disp_height,
    output logic [31:0] screen_base,
    output logic [31:0] ctrl_word,
    output logic [4:0]  disp_bpp,
    output logic        disp_blank,
    output logic        cursor_en,
    output logic [19:0] cursor_x,
    output logic [11:0] cursor_y
);
    fbc_region_e    region;
    logic [8:0]     idx;
    logic           rd_ok;
    logic           soft_rst, clr_all;
    logic [31:0]    width_q, height_q, base_q, ctrl_q, cpos_q;
    logic [23:0]    clut_rd, cpal_rd;
    logic [15:0]    cpat_rd;
    logic [31:0]    rd_mux;
    fbc_ctrl_view_t view;

    fbc_decode u_dec (.addr(bus_addr), .region(region), .idx(idx), .rd_ok(rd_ok));

    assign soft_rst = bus_we && (region == RG_SRST);
    assign clr_all  = rst || soft_rst;

    fbc_table #(.DEPTH(256), .DW(24)) u_clut (
        .clk(clk), .clr(clr_all), .we(bus_we && region == RG_CLUT),
        .widx(idx[7:0]), .wdat(bus_wdata[23:0]), .ridx(pal_idx), .rdat(clut_rd));

    fbc_table #(.DEPTH(3), .DW(24)) u_cpal (
        .clk(clk), .clr(clr_all), .we(bus_we && region == RG_CPAL),
        .widx(idx[1:0]), .wdat(bus_wdata[23:0]), .ridx(idx[1:0]), .rdat(cpal_rd));

    fbc_table #(.DEPTH(512), .DW(16)) u_cpat (
        .clk(clk), .clr(clr_all), .we(bus_we && region == RG_CPAT),
        .widx(idx), .wdat(bus_wdata[15:0]), .ridx(idx), .rdat(cpat_rd));

    fbc_irq u_irq (.clk(clk), .rst(rst), .set(frame_done),
                   .clr(bus_we), .irq(irq));

    always_ff @(posedge clk) begin
        if (clr_all) begin
            width_q  <= '0;
            height_q <= '0;
            base_q   <= '0;
            ctrl_q   <= '0;
            cpos_q   <= '0;
        end else if (bus_we) begin
            case (region)
                RG_WIDTH:  width_q  <= {bus_wdata[29:0], 2'b00};
                RG_HEIGHT: height_q <= {1'b0, bus_wdata[31:1]};
                RG_CTRL:   ctrl_q   <= bus_wdata;
                RG_BASE:   base_q   <= bus_wdata;
                RG_CPOS:   cpos_q   <= bus_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (region)
            RG_CPAT:   rd_mux = {16'h0, cpat_rd};
            RG_CPAL:   rd_mux = {8'h0, cpal_rd};
            RG_WIDTH:  rd_mux = {2'b00, width_q[31:2]};
            RG_HEIGHT: rd_mux = {height_q[30:0], 1'b0};
            RG_CTRL:   rd_mux = ctrl_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
            pal_rgb   <= '0;
        end else begin
            bus_rdata <= (bus_re && rd_ok) ? rd_mux : '0;
            bus_err   <= (bus_re && !rd_ok) || (bus_we && region == RG_NONE);
            pal_rgb   <= clut_rd;
        end
    end

    assign view        = fbc_view(ctrl_q);
    assign disp_width  = width_q;
    assign disp_height = height_q;
    assign screen_base = base_q;
    assign ctrl_word   = ctrl_q;
    assign disp_bpp    = fbc_depth_bpp(view.depth_code);
    assign disp_blank  = view.blank;
    assign cursor_en   = !view.cursor_off;
    assign cursor_x    = cpos_q[31:12];
    assign cursor_y    = cpos_q[11:0];

    // R11: a write that decodes to nothing is flagged on the next cycle
    a_r11_bad_write_flag: assert property (@(posedge clk) disable iff (rst)
        (bus_we && region == RG_NONE) |=> bus_err);
    // R11: a flagged access never returns data
    a_r11_zero_on_err: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_rdata == 32'h0));
    // R12: an idle bus leaves the response quiet
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && !bus_re) |=> (!bus_err && bus_rdata == 32'h0));
    // R8: soft reset clears the scalar settings
    a_r8_soft_clear: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (disp_width == 0 && disp_height == 0 && ctrl_word == 0 &&
                      screen_base == 0 && cursor_x == 0 && cursor_y == 0));
    // R6: only table depths ever reach the pipeline
    a_r6_depth_legal: assert property (@(posedge clk) disable iff (rst)
        disp_bpp inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16});
    // R4: width always lands on a multiple of four pixels
    a_r4_width_aligned: assert property (@(posedge clk) disable iff (rst)
        (bus_we && region == RG_WIDTH) |=> (disp_width[1:0] == 2'b00));
endmodule

// File: tb/fb_ctrl_regs_test.sv
module fb_ctrl_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0, frame_done = 1'b0;
    logic [7:0]  pal_idx = '0;
    logic [31:0] bus_rdata, disp_width, disp_height, screen_base, ctrl_word;
    logic        bus_err, irq, disp_blank, cursor_en;
    logic [23:0] pal_rgb;
    logic [4:0]  disp_bpp;
    logic [19:0] cursor_x;
    logic [11:0] cursor_y;

    int checks = 0, errors = 0;
    logic last_err;

    fb_ctrl_regs uut (.*);

    always #5 clk = ~clk;

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: act=hung exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [20:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0; last_err = bus_err;
    endtask

    task automatic rd(input logic [20:0] a, output logic [31:0] d, output logic e);
        @(negedge clk); bus_addr = a; bus_re = 1'b1;
        @(negedge clk); bus_re = 1'b0; d = bus_rdata; e = bus_err;
    endtask

    task automatic look(input logic [7:0] i, output logic [23:0] c);
        @(negedge clk); pal_idx = i;
        @(negedge clk); c = pal_rgb;
    endtask

    function automatic logic [4:0] exp_bpp(input int code);
        case (code)
            0: return 5'd1;  1: return 5'd2;  2: return 5'd4;
            3: return 5'd8;  4: return 5'd15; 5: return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

    task automatic t_reset_state();
        logic [23:0] c;
        check("R8 reset width", disp_width, 0);
        check("R8 reset ctrl", ctrl_word, 0);
        check("R10 reset irq", {31'h0, irq}, 0);
        check("R12 reset err", {31'h0, bus_err}, 0);
        look(8'd7, c);
        check("R1 reset colour", {8'h0, c}, 0);
    endtask

    task automatic t_clut();
        logic [23:0] c; logic [31:0] d; logic e;
        wr(21'h000800, 32'hFF112233);
        check("R1 write err", {31'h0, last_err}, 0);
        wr(21'h000FF8, 32'h00A0B0C0);
        look(8'd0, c);   check("R1 entry0", {8'h0, c}, 32'h112233);
        look(8'd255, c); check("R1 entry255", {8'h0, c}, 32'hA0B0C0);
        rd(21'h000800, d, e);
        check("R11 clut read err", {31'h0, e}, 1);
        check("R11 clut read data", d, 0);
    endtask

    task automatic t_cpal();
        logic [31:0] d; logic e;
        wr(21'h000508, 32'hEE010203);
        wr(21'h000518, 32'h00ABCDEF);
        rd(21'h000508, d, e); check("R2 cpal0", d, 32'h00010203);
        check("R2 cpal0 err", {31'h0, e}, 0);
        rd(21'h000518, d, e); check("R2 cpal2", d, 32'h00ABCDEF);
        rd(21'h000510, d, e); check("R2 cpal1 untouched", d, 0);
    endtask

    task automatic t_cpat();
        logic [31:0] d; logic e;
        wr(21'h001000, 32'hFFFF1234);
        wr(21'h001FF8, 32'h0000BEEF);
        rd(21'h001000, d, e); check("R3 word0", d, 32'h00001234);
        rd(21'h001FF8, d, e); check("R3 word511", d, 32'h0000BEEF);
        rd(21'h001008, d, e); check("R3 word1", d, 0);
    endtask

    task automatic t_width();
        logic [31:0] d; logic e;
        wr(21'h000118, 32'h00000050);
        check("R4 width", disp_width, 32'h140);
        rd(21'h000118, d, e); check("R4 width read", d, 32'h50);
        // R12: read and write in one cycle, read sees old value
        @(negedge clk); bus_addr = 21'h000118; bus_wdata = 32'h40000123;
        bus_we = 1'b1; bus_re = 1'b1;
        @(negedge clk); bus_we = 1'b0; bus_re = 1'b0;
        check("R12 read before write", bus_rdata, 32'h50);
        check("R4 width truncated", disp_width, 32'h0000048C);
        rd(21'h000118, d, e); check("R4 width read2", d, 32'h00000123);
    endtask

    task automatic t_height();
        logic [31:0] d; logic e;
        wr(21'h000150, 32'h00000151);
        check("R5 height", disp_height, 32'hA8);
        rd(21'h000150, d, e); check("R5 height read", d, 32'h150);
    endtask

    task automatic t_ctrl();
        logic [31:0] d; logic e;
        for (int k = 0; k < 8; k++) begin
            wr(21'h000300, 32'(k) << 20);
            check("R6 bpp", {27'h0, disp_bpp}, {27'h0, exp_bpp(k)});
        end
        wr(21'h000300, 32'h00B00400);
        check("R6 blank", {31'h0, disp_blank}, 1);
        check("R6 cursor off", {31'h0, cursor_en}, 0);
        rd(21'h000300, d, e); check("R6 ctrl read", d, 32'h00B00400);
        wr(21'h000300, 32'h00300000);
        check("R6 cursor on", {31'h0, cursor_en}, 1);
        check("R6 unblank", {31'h0, disp_blank}, 0);
    endtask

    task automatic t_pos();
        logic [31:0] d; logic e;
        wr(21'h000400, 32'h12345678);
        check("R7 base", screen_base, 32'h12345678);
        wr(21'h000638, 32'h00ABC123);
        check("R7 x", {12'h0, cursor_x}, 32'h00ABC);
        check("R7 y", {20'h0, cursor_y}, 32'h123);
        rd(21'h000638, d, e); check("R7 pos write-only", {31'h0, e}, 1);
    endtask

    task automatic t_timing();
        logic [31:0] d; logic e;
        logic [20:0] ta [14] = '{21'h000, 21'h108, 21'h110, 21'h120, 21'h128,
            21'h130, 21'h138, 21'h140, 21'h148, 21'h158, 21'h160, 21'h168,
            21'h170, 21'h200};
        for (int k = 0; k < 14; k++) begin
            wr(ta[k], 32'hFFFFFFFF);
            check("R9 timing no err", {31'h0, last_err}, 0);
        end
        check("R9 width kept", disp_width, 32'h0000048C);
        check("R9 height kept", disp_height, 32'hA8);
        check("R9 base kept", screen_base, 32'h12345678);
        rd(21'h000300, d, e); check("R9 ctrl kept", d, 32'h00300000);
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic e;
        rd(21'h000004, d, e);
        check("R11 bad read err", {31'h0, e}, 1);
        check("R11 bad read data", d, 0);
        @(negedge clk);
        check("R11 err one cycle", {31'h0, bus_err}, 0);
        wr(21'h002000, 32'h00000001);
        check("R11 bad write err", {31'h0, last_err}, 1);
        check("R11 bad write dropped", disp_width, 32'h0000048C);
    endtask

    task automatic t_irq();
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        check("R10 frame sets", {31'h0, irq}, 1);
        wr(21'h000108, 32'h0);
        check("R10 write clears", {31'h0, irq}, 0);
        @(negedge clk); frame_done = 1'b1; bus_we = 1'b1;
        bus_addr = 21'h000300; bus_wdata = 32'h00300000;
        @(negedge clk); frame_done = 1'b0; bus_we = 1'b0;
        check("R10 same cycle set wins", {31'h0, irq}, 1);
        wr(21'h000400, 32'h12345678);
        check("R10 later write clears", {31'h0, irq}, 0);
    endtask

    task automatic t_softreset();
        logic [31:0] d; logic e; logic [23:0] c;
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        wr(21'h100000, 32'h0);
        check("R8 err", {31'h0, last_err}, 0);
        check("R8 irq", {31'h0, irq}, 0);
        check("R8 width", disp_width, 0);
        check("R8 height", disp_height, 0);
        check("R8 base", screen_base, 0);
        check("R8 ctrl", ctrl_word, 0);
        check("R8 pos", {cursor_x, cursor_y}, 0);
        look(8'd0, c); check("R8 colour", {8'h0, c}, 0);
        rd(21'h000508, d, e); check("R8 cpal", d, 0);
        rd(21'h001FF8, d, e); check("R8 cpat", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_clut();
        t_cpal();
        t_cpat();
        t_width();
        t_height();
        t_ctrl();
        t_pos();
        t_timing();
        t_unmapped();
        t_irq();
        t_softreset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule